// File: doc/BRIEF.md
# Three-Group Prioritised Interrupt Status Encoder

This block gathers interrupt requests from three groups: critical, main and peripheral. It builds a single 32-bit encoded status word that names the winning source of each group. The critical group outranks the main group, and the main group outranks the peripheral group. Every group has its own valid bit and source-number field, so one read tells a handler which source to service first.

The main and peripheral groups each have a disable register with one bit per source. Software can also pick peripheral sources for high or medium promotion. A pending promoted high source shows up as a reserved code in the critical field. A pending promoted medium source shows up as a reserved code in the main field. In both cases the peripheral field names the promoted source. The disable registers, the promotion selects and the status word all sit behind one small register port.

The status word is computed combinationally from the requests and the configuration. It is registered once before it is read.

Top module: `irq_status_encoder`

## Requirements
- R1: After synchronous reset the status reads 0. The main disable register reads 0x00010fff, the peripheral disable register reads 0x7ffffc00 and both promotion selects read 0. Reset of the same values also applies when reset is asserted mid-run.
- R2: Register addresses are: 0 main disable, 1 peripheral disable, 2 high-promotion select, 3 medium-promotion select, 4 status. Writes take effect at the clock edge. Read-back returns only implemented bits: main disable bits 16:0, peripheral disable bits 31:10, and promotion select bits 21:0, where bit n selects peripheral source n.
- R3: Main source n (0..16) is disabled when main disable bit 16-n is 1.
- R4: Peripheral source n (0..21) is disabled when peripheral disable bit 31-n is 1.
- R5: Within the main and peripheral groups, the lowest-numbered enabled pending source wins. The main code sits in status bits 20:16 with valid bit 21. The peripheral code sits in bits 28:24 with valid bit 29.
- R6: Critical sources 0 and 1 cannot be disabled. The critical code sits in bits 9:8 with valid bit 10, and the lowest code wins.
- R7: The request input of main source 4 is ignored, because code 4 in the main field is reserved.
- R8: An enabled pending peripheral source with its high-select bit set places code 2 in the critical field. That code loses to critical sources 0 and 1. The peripheral field then names the lowest such high-promoted source, ahead of any other peripheral source.
- R9: An enabled pending peripheral source with its medium-select bit set and its high-select bit clear places code 4 in the main field. That code loses to main sources 0 to 3. Without a high-promoted source, the peripheral field names the lowest such medium-promoted source. When both select bits are set, high promotion takes precedence.
- R10: The status word reflects requests sampled at the previous clock edge. Writes to the status address have no effect.
- R11: A field whose valid bit is 0 reads as zero, and every status bit outside the three fields and valid bits reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crit_req | input | 2 | Critical group requests, bit n is source n |
| main_req | input | 17 | Main group requests, bit n is source n |
| per_req | input | 22 | Peripheral group requests, bit n is source n |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational from registered state |

## Verification
Single-source and multi-source request patterns in each group check that the lowest enabled source wins. They also check that each code lands in its own field. Patterns that pair a low-numbered disabled source with a higher enabled one tell the reversed mask bit mapping apart from a direct one. Promotion patterns mix high and medium selects with real critical and main requests, and this separates the reserved-code ranking from plain index ordering. A one-edge request pulse shows that status comes from exactly one register stage.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;

    localparam int REG_AW   = 3;
    localparam int WORD_W   = 32;
    localparam int CRIT_N   = 2;
    localparam int CRIT_W   = 2;
    localparam int CODE_W   = 5;
    localparam int MAIN_MSB = 16;
    localparam int PER_MSB  = 31;

    localparam logic [CRIT_W-1:0] CRIT_CODE_HI  = 2'd2;
    localparam logic [CODE_W-1:0] MAIN_CODE_MED = 5'd4;
    localparam int                MAIN_MED_IDX  = 4;

    localparam logic [WORD_W-1:0] MAIN_DIS_RST = 32'h0001_0fff;
    localparam logic [WORD_W-1:0] PER_DIS_RST  = 32'h7fff_fc00;

    typedef enum logic [REG_AW-1:0] {
        A_MAIN_DIS = 3'd0,
        A_PER_DIS  = 3'd1,
        A_HI_SEL   = 3'd2,
        A_MED_SEL  = 3'd3,
        A_STATUS   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [1:0]        rsv_top;
        logic              per_vld;
        logic [CODE_W-1:0] per_code;
        logic [1:0]        rsv_mid;
        logic              main_vld;
        logic [CODE_W-1:0] main_code;
        logic [4:0]        rsv_low;
        logic              crit_vld;
        logic [CRIT_W-1:0] crit_code;
        logic [7:0]        rsv_bot;
    } status_t;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/irq_enc_regs.sv
module irq_enc_regs
    import irq_enc_pkg::*;
#(
    parameter int MAIN_N = 17,
    parameter int PER_N  = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [MAIN_N-1:0] main_dis,
    output logic [PER_N-1:0]  per_dis,
    output logic [PER_N-1:0]  hi_sel,
    output logic [PER_N-1:0]  med_sel,
    output logic [WORD_W-1:0] rd_cfg
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < MAIN_N; n++) main_dis[n] <= MAIN_DIS_RST[MAIN_MSB-n];
            for (int n = 0; n < PER_N; n++)  per_dis[n]  <= PER_DIS_RST[PER_MSB-n];
            hi_sel  <= '0;
            med_sel <= '0;
        end else if (wr) begin
            case (sel)
                A_MAIN_DIS: for (int n = 0; n < MAIN_N; n++) main_dis[n] <= wdata[MAIN_MSB-n];
                A_PER_DIS:  for (int n = 0; n < PER_N; n++)  per_dis[n]  <= wdata[PER_MSB-n];
                A_HI_SEL:   hi_sel  <= wdata[PER_N-1:0];
                A_MED_SEL:  med_sel <= wdata[PER_N-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_cfg = '0;
        case (sel)
            A_MAIN_DIS: for (int n = 0; n < MAIN_N; n++) rd_cfg[MAIN_MSB-n] = main_dis[n];
            A_PER_DIS:  for (int n = 0; n < PER_N; n++)  rd_cfg[PER_MSB-n]  = per_dis[n];
            A_HI_SEL:   rd_cfg[PER_N-1:0] = hi_sel;
            A_MED_SEL:  rd_cfg[PER_N-1:0] = med_sel;
            default:    rd_cfg = '0;
        endcase
    end
endmodule

// File: rtl/irq_enc_status.sv
module irq_enc_status
    import irq_enc_pkg::*;
#(
    parameter int MAIN_N = 17,
    parameter int PER_N  = 22
) (
    input  logic [CRIT_N-1:0] crit_req,
    input  logic [MAIN_N-1:0] main_req,
    input  logic [PER_N-1:0]  per_req,
    input  logic [MAIN_N-1:0] main_dis,
    input  logic [PER_N-1:0]  per_dis,
    input  logic [PER_N-1:0]  hi_sel,
    input  logic [PER_N-1:0]  med_sel,
    output status_t           word
);
    localparam int CRIT_SLOTS = 1 << CRIT_W;

    logic [PER_N-1:0]      per_act, hi_act, med_act;
    logic [MAIN_N-1:0]     main_cand;
    logic [CRIT_SLOTS-1:0] crit_cand;

    always_comb begin
        per_act = per_req & ~per_dis;
        hi_act  = per_act & hi_sel;
        med_act = per_act & med_sel & ~hi_sel;

        main_cand               = main_req & ~main_dis;
        main_cand[MAIN_MED_IDX] = |med_act;

        crit_cand                       = '0;
        crit_cand[CRIT_N-1:0]           = crit_req;
        crit_cand[int'(CRIT_CODE_HI)]   = |hi_act;
    end

    logic              crit_any, main_any, per_any, hi_any, med_any;
    logic [CRIT_W-1:0] crit_idx;
    logic [CODE_W-1:0] main_idx, per_idx, hi_idx, med_idx;

    irq_prio_pick #(.N(CRIT_SLOTS), .W(CRIT_W)) u_crit (.req(crit_cand), .any(crit_any), .idx(crit_idx));
    irq_prio_pick #(.N(MAIN_N), .W(CODE_W)) u_main (.req(main_cand), .any(main_any), .idx(main_idx));
    irq_prio_pick #(.N(PER_N), .W(CODE_W))  u_per  (.req(per_act),  .any(per_any),  .idx(per_idx));
    irq_prio_pick #(.N(PER_N), .W(CODE_W))  u_hi   (.req(hi_act),   .any(hi_any),   .idx(hi_idx));
    irq_prio_pick #(.N(PER_N), .W(CODE_W))  u_med  (.req(med_act),  .any(med_any),  .idx(med_idx));

    always_comb begin
        word           = '0;
        word.crit_vld  = crit_any;
        word.crit_code = crit_idx;
        word.main_vld  = main_any;
        word.main_code = main_idx;
        word.per_vld   = per_any;
        if (hi_any)       word.per_code = hi_idx;
        else if (med_any) word.per_code = med_idx;
        else              word.per_code = per_idx;
    end
endmodule

// File: rtl/irq_status_encoder.sv
module irq_status_encoder
    import irq_enc_pkg::*;
#(
    parameter int MAIN_N = 17,
    parameter int PER_N  = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CRIT_N-1:0] crit_req,
    input  logic [MAIN_N-1:0] main_req,
    input  logic [PER_N-1:0]  per_req,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    logic [MAIN_N-1:0] main_dis;
    logic [PER_N-1:0]  per_dis, hi_sel, med_sel;
    logic [WORD_W-1:0] rd_cfg;
    status_t           status_d, status_q;

    irq_enc_regs #(.MAIN_N(MAIN_N), .PER_N(PER_N)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .main_dis(main_dis), .per_dis(per_dis), .hi_sel(hi_sel), .med_sel(med_sel),
        .rd_cfg(rd_cfg)
    );

    irq_enc_status #(.MAIN_N(MAIN_N), .PER_N(PER_N)) u_status (
        .crit_req(crit_req), .main_req(main_req), .per_req(per_req),
        .main_dis(main_dis), .per_dis(per_dis), .hi_sel(hi_sel), .med_sel(med_sel),
        .word(status_d)
    );

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

    assign reg_rdata = (reg_addr_e'(reg_addr) == A_STATUS) ? status_q : rd_cfg;
endmodule

// File: rtl/irq_status_encoder_chk.sv
module irq_status_encoder_chk
    import irq_enc_pkg::*;
#(
    parameter int MAIN_N = 17,
    parameter int PER_N  = 22
) (
    input logic              clk,
    input logic              rst,
    input logic [CRIT_N-1:0] crit_req,
    input logic [MAIN_N-1:0] main_req,
    input logic [PER_N-1:0]  per_req,
    input status_t           status_q
);
    // R6: critical source 0 always wins the critical field one edge later
    p_crit_lowest_r6: assert property (@(posedge clk) disable iff (rst)
        crit_req[0] |=> (status_q.crit_vld && status_q.crit_code == 2'd0));

    // R8: promoted-high tag implies a named peripheral source
    p_hi_tag_r8: assert property (@(posedge clk) disable iff (rst)
        (status_q.crit_vld && status_q.crit_code == CRIT_CODE_HI) |-> status_q.per_vld);

    // R9: promoted-medium tag implies a named peripheral source
    p_med_tag_r9: assert property (@(posedge clk) disable iff (rst)
        (status_q.main_vld && status_q.main_code == MAIN_CODE_MED) |-> status_q.per_vld);

    // R5: no requests at all gives no valid field next cycle
    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!(|crit_req) && !(|main_req) && !(|per_req)) |=>
        (!status_q.crit_vld && !status_q.main_vld && !status_q.per_vld));

    // R11: reserved bits and codes of invalid fields stay zero
    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (status_q.rsv_top == '0 && status_q.rsv_mid == '0 && status_q.rsv_low == '0 &&
         status_q.rsv_bot == '0 &&
         (status_q.crit_vld || status_q.crit_code == '0) &&
         (status_q.main_vld || status_q.main_code == '0) &&
         (status_q.per_vld  || status_q.per_code  == '0)));

    // R7: main code stays inside the implemented source range
    p_main_range_r7: assert property (@(posedge clk) disable iff (rst)
        status_q.main_vld |-> (int'(status_q.main_code) < MAIN_N));
endmodule

bind irq_status_encoder irq_status_encoder_chk #(.MAIN_N(MAIN_N), .PER_N(PER_N)) chk_i (
    .clk(clk), .rst(rst), .crit_req(crit_req), .main_req(main_req),
    .per_req(per_req), .status_q(status_q)
);

// File: tb/irq_status_encoder_tb.sv
module irq_status_encoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  crit_req = '0;
    logic [16:0] main_req = '0;
    logic [21:0] per_req = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_status_encoder dut_i (
        .clk(clk), .rst(rst), .crit_req(crit_req), .main_req(main_req), .per_req(per_req),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic [3:0]  tag;
        logic [1:0]  crit;
        logic [16:0] mreq;
        logic [21:0] preq;
        logic [31:0] mdis;
        logic [31:0] pdis;
        logic [21:0] hi;
        logic [21:0] med;
        logic [31:0] expv;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{4'd5, 2'b00, 17'h00088, 22'h000000, 32'h0, 32'h0, 22'h0, 22'h0, 32'h0023_0000}, // R5 main lowest
        '{4'd5, 2'b00, 17'h00000, 22'h100020, 32'h0, 32'h0, 22'h0, 22'h0, 32'h2500_0000}, // R5 periph lowest
        '{4'd6, 2'b10, 17'h10000, 22'h000000, 32'h0, 32'h0, 22'h0, 22'h0, 32'h0030_0500}, // R6 crit 1 + main 16
        '{4'd6, 2'b11, 17'h00000, 22'h000000, 32'h0, 32'h0, 22'h0, 22'h0, 32'h0000_0400}, // R6 crit 0 beats 1
        '{4'd3, 2'b00, 17'h00204, 22'h000000, 32'h0000_4000, 32'h0, 22'h0, 22'h0, 32'h0029_0000}, // R3
        '{4'd4, 2'b00, 17'h00000, 22'h000009, 32'h0, 32'h8000_0000, 22'h0, 22'h0, 32'h2300_0000}, // R4
        '{4'd7, 2'b00, 17'h00050, 22'h000000, 32'h0, 32'h0, 22'h0, 22'h0, 32'h0026_0000}, // R7
        '{4'd7, 2'b00, 17'h00010, 22'h000000, 32'h0, 32'h0, 22'h0, 22'h0, 32'h0000_0000}, // R7 alone
        '{4'd8, 2'b00, 17'h00000, 22'h000204, 32'h0, 32'h0, 22'h000200, 22'h0, 32'h2900_0600}, // R8
        '{4'd8, 2'b01, 17'h00000, 22'h000204, 32'h0, 32'h0, 22'h000200, 22'h0, 32'h2900_0400}, // R8 crit 0 wins
        '{4'd9, 2'b00, 17'h00000, 22'h000204, 32'h0, 32'h0, 22'h0, 22'h000200, 32'h2924_0000}, // R9
        '{4'd9, 2'b00, 17'h00002, 22'h000204, 32'h0, 32'h0, 22'h0, 22'h000200, 32'h2921_0000}, // R9 main 1 wins
        '{4'd9, 2'b00, 17'h00000, 22'h001008, 32'h0, 32'h0, 22'h001000, 22'h000008, 32'h2c24_0600}, // R9 hi over med
        '{4'd8, 2'b00, 17'h00000, 22'h0000a0, 32'h0, 32'h0400_0000, 22'h000020, 22'h0, 32'h2700_0000}, // R8 masked promo
        '{4'd9, 2'b00, 17'h00000, 22'h000200, 32'h0, 32'h0, 22'h000200, 22'h000200, 32'h2900_0600}, // R9 both selects
        '{4'd11, 2'b00, 17'h00000, 22'h000000, 32'h0, 32'h0, 22'h0, 22'h0, 32'h0000_0000}, // R11 idle
        '{4'd3, 2'b00, 17'h1ffff, 22'h3fffff, 32'h0001_ffff, 32'hffff_fc00, 22'h0, 22'h0, 32'h0} // R3 all off
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, expv);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_reset_state(input string req);
        logic [31:0] v;
        rd_reg(3'd4, v); check(req, v, 32'h0);
        rd_reg(3'd0, v); check(req, v, 32'h0001_0fff);
        rd_reg(3'd1, v); check(req, v, 32'h7fff_fc00);
        rd_reg(3'd2, v); check(req, v, 32'h0);
        rd_reg(3'd3, v); check(req, v, 32'h0);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset_state("R1");

        // R2: read-back returns implemented bits only
        wr_reg(3'd0, 32'hffff_ffff); rd_reg(3'd0, v); check("R2", v, 32'h0001_ffff);
        wr_reg(3'd1, 32'hffff_ffff); rd_reg(3'd1, v); check("R2", v, 32'hffff_fc00);
        wr_reg(3'd2, 32'hffff_ffff); rd_reg(3'd2, v); check("R2", v, 32'h003f_ffff);
        wr_reg(3'd3, 32'hffff_ffff); rd_reg(3'd3, v); check("R2", v, 32'h003f_ffff);
        rd_reg(3'd5, v); check("R2", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr_reg(3'd0, VECS[i].mdis);
            wr_reg(3'd1, VECS[i].pdis);
            wr_reg(3'd2, {10'd0, VECS[i].hi});
            wr_reg(3'd3, {10'd0, VECS[i].med});
            crit_req = VECS[i].crit; main_req = VECS[i].mreq; per_req = VECS[i].preq;
            @(negedge clk);
            rd_reg(3'd4, v);
            check($sformatf("R%0d vector %0d", VECS[i].tag, i), v, VECS[i].expv);
            crit_req = '0; main_req = '0; per_req = '0;
            @(negedge clk);
        end

        // R10: write to status address has no effect
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd4, 32'hffff_ffff);
        rd_reg(3'd4, v); check("R10 status write", v, 32'h0);
        rd_reg(3'd0, v); check("R10 mask kept", v, 32'h0);

        // R10: exactly one register stage
        @(negedge clk);
        main_req = 17'h00002;
        rd_reg(3'd4, v); check("R10 before edge", v, 32'h0);
        @(negedge clk);
        main_req = '0;
        rd_reg(3'd4, v); check("R10 after edge", v, 32'h0021_0000);
        @(negedge clk);
        rd_reg(3'd4, v); check("R10 drop", v, 32'h0);

        // R1: mid-run reset restores defaults
        wr_reg(3'd2, 32'h0000_0fff);
        per_req = 22'h000001;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        per_req = '0;
        check_reset_state("R1 mid-run");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule